// File: doc/BRIEF.md
# Streaming Hamming ECC Generator

This block folds a stream of bytes, as they cross a byte-wide transfer port, into a Hamming-style error-correcting code of the kind used for small-page flash. Each code has two parts. The column parity holds six bits formed from groups of bit positions across all bytes. The line parity holds complementary pairs formed from the parity of each whole byte, split by each bit of the byte's offset in the block.

An arm strobe clears every result byte, clears the done flag, and samples the mode input. In split mode the block produces two independent codes, one over the first block of 2^LOG_BLK bytes and one over the block that follows. In joined mode it produces one code over both blocks taken as one, and that code carries two more line-parity bits. After 2^(LOG_BLK+1) accepted bytes the block raises done and stops. It then ignores traffic until the next arm. The six result bytes can be read at any time through a small combinational address/data read port. LOG_BLK may range from 1 to 8. The default of 8 gives two 256-byte blocks or one 512-byte block.

Top module: `ecc_stream_gen`

## Requirements
- R1: After reset, and until the first arm, done_o and active_o are low, all line and column parity bits are zero, and bytes presented on the port change nothing.
- R2: An arm pulse (arm_i high for one cycle) clears all parity bits and done_o, sets active_o, and restarts at byte offset zero, including in the middle of a stream. A byte presented in the same cycle as arm_i is dropped.
- R3: mode_full_i is sampled only in the arm cycle (1 = one joined code, 0 = two split codes). Changing it later has no effect on the running calculation.
- R4: Column parity bit 2j+1 is the XOR of all data bits at positions whose index has bit j set. Bit 2j is the XOR of the data bits at the other positions (j = 0..2). The six bits read as bits 7:2 of result byte 2 of each code, with bit 2j at position 2j+2.
- R5: Line parity bit 2k+1 is the XOR of the parities of all bytes whose in-block offset has bit k set. Bit 2k is the XOR of the parities of the bytes where that offset bit is clear. In the 18-bit line-parity vector, bits 7:0 read as byte 1, bits 15:8 as byte 0, and bits 17:16 as bits 1:0 of byte 2.
- R6: In split mode, code A (read addresses 0..2) covers offsets 0..2^LOG_BLK-1 and code B (addresses 3..5) covers the next 2^LOG_BLK bytes. Each uses the layout of R4 and R5 with 2·LOG_BLK line-parity bits.
- R7: In joined mode, code A covers all 2^(LOG_BLK+1) bytes with 2·LOG_BLK+2 line-parity bits, and addresses 3..5 read zero.
- R8: Line-parity positions beyond the width in use read as 1. Read addresses 6 and 7 read zero. rd_data_o follows rd_addr_i with no clock.
- R9: On the clock edge that accepts the last byte of the window, done_o rises and active_o falls. The two are never high together, and later bytes change nothing until the next arm.
- R10: Cycles with byte_vld_i low neither advance the byte offset nor change any parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_full_i | input | 1 | 1 selects one joined code, 0 selects two split codes; sampled on arm |
| arm_i | input | 1 | One-cycle strobe: clear results and start a new window |
| byte_vld_i | input | 1 | A byte is transferred this cycle |
| byte_i | input | 8 | Transferred byte |
| rd_addr_i | input | 3 | Result byte select (0..2 code A, 3..5 code B) |
| rd_data_o | output | 8 | Selected result byte |
| active_o | output | 1 | Window armed and not yet complete |
| done_o | output | 1 | Window of 2^(LOG_BLK+1) bytes complete |

## Verification
The bench builds the block with LOG_BLK = 2, so each block is four bytes long and a full window is eight bytes. This makes it practical to sweep a single set bit through every bit position at every byte offset in both modes. Together those runs reach every column and line parity pair, including the two extra line bits of the joined code and the padding bits that read as 1. The short window also makes room for pseudo-random streams with idle gaps, restarts in the middle of a stream, an arm that collides with a byte, mode changes while a window runs, and traffic after done.

// File: rtl/ecc_stream_pkg.sv
package ecc_stream_pkg;
  localparam int BYTE_W = 8;
  localparam int COL_W  = 6;
  localparam int LP_MAX = 18;

  // bit 2j+1: positions with index bit j set; bit 2j: the rest
  function automatic logic [COL_W-1:0] col_parity(input logic [BYTE_W-1:0] b);
    logic [COL_W-1:0] r;
    r = '0;
    for (int p = 0; p < BYTE_W; p++) begin
      for (int j = 0; j < 3; j++) begin
        if (p[j]) r[2*j+1] = r[2*j+1] ^ b[p];
        else      r[2*j]   = r[2*j]   ^ b[p];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_seq_ctrl.sv
module ecc_seq_ctrl #(
  parameter int LOG_BLK = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             mode_full_i,
  input  logic             byte_vld_i,
  output logic             take_o,
  output logic [LOG_BLK:0] pos_o,
  output logic             full_o,
  output logic             active_o,
  output logic             done_o
);
  localparam int CNT_W = LOG_BLK + 1;
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic active_q, done_q, full_q;

  assign take_o = active_q & byte_vld_i & ~arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      full_q   <= 1'b0;
    end else if (arm_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
      done_q   <= 1'b0;
      full_q   <= mode_full_i;
    end else if (take_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign pos_o    = cnt_q;
  assign full_o   = full_q;
  assign active_o = active_q;
  assign done_o   = done_q;
endmodule

// File: rtl/ecc_code_acc.sv
module ecc_code_acc
  import ecc_stream_pkg::*;
#(
  parameter int LOG_BLK = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   en_i,
  input  logic                   wide_i,
  input  logic                   par_i,
  input  logic [COL_W-1:0]       col_i,
  input  logic [LOG_BLK:0]       addr_i,
  output logic [2*LOG_BLK+1:0]   lp_o,
  output logic [COL_W-1:0]       cp_o
);
  localparam int LPW = 2 * LOG_BLK + 2;

  logic [LPW-1:0]   lp_q, lp_d;
  logic [COL_W-1:0] cp_q, cp_d;

  always_comb begin
    lp_d = lp_q;
    cp_d = cp_q ^ col_i;
    for (int k = 0; k <= LOG_BLK; k++) begin
      // top offset bit is the block select unless the code spans both blocks
      if (k < LOG_BLK || wide_i) lp_d[2*k + int'(addr_i[k])] = lp_d[2*k + int'(addr_i[k])] ^ par_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr_i) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (en_i) begin
      lp_q <= lp_d;
      cp_q <= cp_d;
    end
  end

  assign lp_o = lp_q;
  assign cp_o = cp_q;
endmodule

// File: rtl/ecc_rd_mux.sv
module ecc_rd_mux
  import ecc_stream_pkg::*;
#(
  parameter int LOG_BLK = 8
) (
  input  logic                 full_i,
  input  logic [2*LOG_BLK+1:0] lp_a_i,
  input  logic [COL_W-1:0]     cp_a_i,
  input  logic [2*LOG_BLK+1:0] lp_b_i,
  input  logic [COL_W-1:0]     cp_b_i,
  input  logic [2:0]           addr_i,
  output logic [BYTE_W-1:0]    data_o
);
  localparam int LPW = 2 * LOG_BLK + 2;

  logic [LP_MAX-1:0] raw_a, raw_b, ext_a, ext_b;
  int used;

  always_comb begin
    raw_a = LP_MAX'(lp_a_i);
    raw_b = LP_MAX'(lp_b_i);
    used  = full_i ? LPW : LPW - 2;
    for (int j = 0; j < LP_MAX; j++) begin
      ext_a[j] = (j < used) ? raw_a[j] : 1'b1;
      ext_b[j] = (j < LPW - 2) ? raw_b[j] : 1'b1;
    end
  end

  always_comb begin
    case (addr_i)
      3'd0:    data_o = ext_a[15:8];
      3'd1:    data_o = ext_a[7:0];
      3'd2:    data_o = {cp_a_i, ext_a[17:16]};
      3'd3:    data_o = full_i ? '0 : ext_b[15:8];
      3'd4:    data_o = full_i ? '0 : ext_b[7:0];
      3'd5:    data_o = full_i ? '0 : {cp_b_i, ext_b[17:16]};
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
  import ecc_stream_pkg::*;
#(
  parameter int LOG_BLK = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_full_i,
  input  logic              arm_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [2:0]        rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              active_o,
  output logic              done_o
);
  localparam int LPW = 2 * LOG_BLK + 2;

  logic             take, full_q, blk_sel, par;
  logic [LOG_BLK:0] pos;
  logic [COL_W-1:0] col;
  logic [1:0]       acc_en, acc_wide;
  logic [LPW-1:0]   lp_arr [2];
  logic [COL_W-1:0] cp_arr [2];
  logic [LPW-1:0]   lp_a, lp_b;
  logic [COL_W-1:0] cp_a, cp_b;

  ecc_seq_ctrl #(.LOG_BLK(LOG_BLK)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .mode_full_i(mode_full_i),
    .byte_vld_i (byte_vld_i),
    .take_o     (take),
    .pos_o      (pos),
    .full_o     (full_q),
    .active_o   (active_o),
    .done_o     (done_o)
  );

  assign par     = ^byte_i;
  assign col     = col_parity(byte_i);
  assign blk_sel = pos[LOG_BLK];

  assign acc_en[0]   = take & (full_q | ~blk_sel);
  assign acc_en[1]   = take & ~full_q & blk_sel;
  assign acc_wide[0] = full_q;
  assign acc_wide[1] = 1'b0;

  for (genvar g = 0; g < 2; g++) begin : g_code
    ecc_code_acc #(.LOG_BLK(LOG_BLK)) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (arm_i),
      .en_i  (acc_en[g]),
      .wide_i(acc_wide[g]),
      .par_i (par),
      .col_i (col),
      .addr_i(pos),
      .lp_o  (lp_arr[g]),
      .cp_o  (cp_arr[g])
    );
  end

  assign lp_a = lp_arr[0];
  assign cp_a = cp_arr[0];
  assign lp_b = lp_arr[1];
  assign cp_b = cp_arr[1];

  ecc_rd_mux #(.LOG_BLK(LOG_BLK)) u_mux (
    .full_i(full_q),
    .lp_a_i(lp_a),
    .cp_a_i(cp_a),
    .lp_b_i(lp_b),
    .cp_b_i(cp_b),
    .addr_i(rd_addr_i),
    .data_o(rd_data_o)
  );
endmodule

// File: rtl/ecc_stream_chk.sv
module ecc_stream_chk #(
  parameter int LOG_BLK = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 arm_i,
  input logic                 byte_vld_i,
  input logic                 active_o,
  input logic                 done_o,
  input logic                 full_q,
  input logic [2*LOG_BLK+1:0] lp_a,
  input logic [2*LOG_BLK+1:0] lp_b,
  input logic [5:0]           cp_a,
  input logic [5:0]           cp_b
);
  // R2
  arm_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> active_o && !done_o && lp_a == '0 && lp_b == '0 && cp_a == '0 && cp_b == '0);

  // R1
  idle_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !arm_i) |=> ($stable(lp_a) && $stable(lp_b) && $stable(cp_a) && $stable(cp_b) && $stable(done_o)));

  // R3
  mode_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !arm_i) |=> $stable(full_q));

  // R7
  joined_b_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> (lp_b == '0 && cp_b == '0));

  // R9
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_o && done_o));

  // R9
  done_from_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(active_o));

  // R10
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !byte_vld_i && !arm_i) |=> ($stable(lp_a) && $stable(lp_b) && $stable(cp_a) && $stable(cp_b) && $stable(active_o)));
endmodule

bind ecc_stream_gen ecc_stream_chk #(.LOG_BLK(LOG_BLK)) i_ecc_stream_chk (.*);

// File: tb/test_ecc_stream_gen.sv
`timescale 1ns/1ps
module test_ecc_stream_gen;
  localparam int LB  = 2;
  localparam int N   = 1 << LB;
  localparam int TOT = 2 * N;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_full_i = 1'b0;
  logic       arm_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       active_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] dat [TOT];
  logic [7:0] exp_b [8];

  always #2 clk_i = ~clk_i;

  ecc_stream_gen #(.LOG_BLK(LB)) i_ecc_stream_gen (.*);

  task automatic chk(input string tag, input string ctx, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s (%s): got %h expected %h", tag, ctx, got, exp);
    end
  endtask

  task automatic calc_exp(input bit full, input int n);
    logic [17:0] lpx [2];
    logic [5:0]  cpx [2];
    logic [7:0]  d;
    logic [5:0]  cv;
    int used;
    lpx[0] = '0; lpx[1] = '0; cpx[0] = '0; cpx[1] = '0;
    for (int i = 0; i < n; i++) begin
      d  = dat[i];
      cv = {^(d & 8'hF0), ^(d & 8'h0F), ^(d & 8'hCC), ^(d & 8'h33), ^(d & 8'hAA), ^(d & 8'h55)};
      if (full) begin
        for (int k = 0; k <= LB; k++) lpx[0][2*k + ((i >> k) & 1)] ^= ^d;
        cpx[0] ^= cv;
      end else begin
        for (int k = 0; k < LB; k++) lpx[i / N][2*k + (((i % N) >> k) & 1)] ^= ^d;
        cpx[i / N] ^= cv;
      end
    end
    used = full ? 2*LB + 2 : 2*LB;
    for (int j = 0; j < 18; j++) begin
      if (j >= used) lpx[0][j] = 1'b1;
      if (j >= 2*LB) lpx[1][j] = 1'b1;
    end
    exp_b[0] = lpx[0][15:8];
    exp_b[1] = lpx[0][7:0];
    exp_b[2] = {cpx[0], lpx[0][17:16]};
    exp_b[3] = full ? 8'h00 : lpx[1][15:8];
    exp_b[4] = full ? 8'h00 : lpx[1][7:0];
    exp_b[5] = full ? 8'h00 : {cpx[1], lpx[1][17:16]};
    exp_b[6] = 8'h00;
    exp_b[7] = 8'h00;
  endtask

  task automatic check_all(input string ctx, input bit full, input int n, input bit edone, input bit eact);
    calc_exp(full, n);
    for (int a = 0; a < 8; a++) begin
      rd_addr_i = a[2:0];
      #0.1;
      chk(a >= 6 ? "R8" : (a % 3 == 2 ? "R4" : "R5"), $sformatf("%s addr %0d", ctx, a), rd_data_o, exp_b[a]);
    end
    chk("R9", {ctx, " done"}, done_o, edone);
    chk("R9", {ctx, " active"}, active_o, eact);
  endtask

  task automatic arm_go(input bit full, input bit with_byte, input logic [7:0] b);
    arm_i = 1'b1; mode_full_i = full; byte_vld_i = with_byte; byte_i = b;
    @(negedge clk_i);
    arm_i = 1'b0; byte_vld_i = 1'b0;
  endtask

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      byte_i = dat[i]; byte_vld_i = 1'b1;
      @(negedge clk_i);
      byte_vld_i = 1'b0;
      if (gaps && (i % 2 == 1)) @(negedge clk_i);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TOT; i++) dat[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state, split-mode layout with padding ones (R8)
    check_all("R1 reset", 1'b0, 0, 1'b0, 1'b0);
    // R1: traffic before the first arm is ignored
    for (int i = 0; i < TOT; i++) dat[i] = 8'hA5 ^ 8'(i);
    feed(TOT, 1'b0);
    for (int i = 0; i < TOT; i++) dat[i] = 8'h00;
    check_all("R1 pre-arm", 1'b0, 0, 1'b0, 1'b0);

    // R4 R5 R6 R7: single set bit swept over every offset and position
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < TOT; p++) begin
        for (int b = 0; b < 8; b++) begin
          for (int i = 0; i < TOT; i++) dat[i] = (i == p) ? 8'(1 << b) : 8'h00;
          arm_go(m[0], 1'b0, 8'h00);
          feed(TOT, 1'b0);
          check_all(m ? "R7 sweep" : "R6 sweep", m[0], TOT, 1'b1, 1'b0);
        end
      end
    end

    // R10: pseudo-random streams with idle gaps
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 16; s++) begin
        for (int i = 0; i < TOT; i++) dat[i] = 8'((s * 37 + i * 91 + (i * i) * 13) ^ (s << 3));
        arm_go(m[0], 1'b0, 8'h00);
        feed(TOT, 1'b1);
        check_all(m ? "R10 R7 gaps" : "R10 R6 gaps", m[0], TOT, 1'b1, 1'b0);
      end
    end

    // R10: partial window, still active
    for (int i = 0; i < TOT; i++) dat[i] = 8'h3C + 8'(i * 17);
    arm_go(1'b0, 1'b0, 8'h00);
    feed(N + 1, 1'b1);
    check_all("R10 partial", 1'b0, N + 1, 1'b0, 1'b1);
    // R2: restart mid-stream
    arm_go(1'b1, 1'b0, 8'h00);
    check_all("R2 rearm clear", 1'b1, 0, 1'b0, 1'b1);
    feed(TOT, 1'b0);
    check_all("R2 restart", 1'b1, TOT, 1'b1, 1'b0);
    // R9: bytes after done are ignored
    feed(3, 1'b0);
    check_all("R9 post-done", 1'b1, TOT, 1'b1, 1'b0);

    // R2: byte colliding with arm is dropped
    for (int i = 0; i < TOT; i++) dat[i] = 8'h81 ^ 8'(i * 29);
    arm_go(1'b0, 1'b1, 8'hFF);
    feed(TOT, 1'b0);
    check_all("R2 collide", 1'b0, TOT, 1'b1, 1'b0);

    // R3: mode input changed while a window runs
    for (int i = 0; i < TOT; i++) dat[i] = 8'h5A + 8'(i * 71);
    arm_go(1'b0, 1'b0, 8'h00);
    mode_full_i = 1'b1;
    feed(TOT, 1'b0);
    check_all("R3 split held", 1'b0, TOT, 1'b1, 1'b0);
    arm_go(1'b1, 1'b0, 8'h00);
    mode_full_i = 1'b0;
    feed(TOT, 1'b0);
    check_all("R3 joined held", 1'b1, TOT, 1'b1, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule